// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Word-Boundary Slip

This block deserializes a stream of one bit per clock into a 4-bit parallel word, all in a single clock domain. The serial bit is taken from one of two inputs, picked by a select pin. The second input lets a transmit path be looped straight back for link testing. The parallel word sits in a holding register. That register is loaded on the terminal count of an internal phase counter and stays still for the whole word period.

The phase counter also drives two framing square waves, at one quarter and one eighth of the clock rate. A mode pin stretches the word period from four clocks to eight. In that mode two instances can be chained into an 8-bit converter: the first instance's serial output, which is the input stream delayed by four clocks, feeds the second instance.

A slip request moves the word boundary by one bit. The request may be asynchronous. It passes a two-flop synchronizer into a small state machine, which makes the counter hold its value for exactly one clock per request, however long the request is held. The states are SLIP_IDLE, SLIP_SWALLOW and SLIP_HELD, with these transitions:
- SLIP_IDLE goes to SLIP_SWALLOW when the synchronized request is high.
- SLIP_SWALLOW goes to SLIP_HELD while the request stays high, or back to SLIP_IDLE if it has dropped.
- SLIP_HELD goes back to SLIP_IDLE when the request drops.

A synchronous reset puts every instance at the same counter phase.

Top module: `sp_slip_deser`

## Requirements
- R1: On each word load, par_q[0] holds the earliest of the four most recent serial bits and par_q[3] the latest; with mode low, the first word after reset holds the first four bits received.
- R2: With sel_a high the serial bit comes from ser_a; with sel_a low it comes from ser_b; the unselected input has no effect on any output.
- R3: With wide_mode low, par_q loads on every fourth clock and holds its value on all other clocks.
- R4: With wide_mode high, par_q loads on every eighth clock with the last four of those eight bits (the 5th to 8th after reset for the first load), bit order as in R1.
- R5: frame_div4 is the counter phase bit of period 4 and frame_div8 that of period 8; both are low after reset; frame_div4 falls on the edge of each 4-clock load; frame_div8 changes only on edges where frame_div4 falls.
- R6: ser_out, from the fourth clock after reset onward, equals the selected serial bit sampled four clock edges earlier; it is 0 before that.
- R7: A rising slip_req first sampled high at edge E makes the phase counter skip exactly one count at edge E+3; a request held high for many clocks causes only one skip.
- R8: On a skipped edge par_q, frame_div4 and frame_div8 keep their values, while the serial path keeps shifting; every later word is made of bits one position later, so the bit that was on par_q[n] moves to par_q[n-1].
- R9: While rst is high at a clock edge, par_q, frame_div4, frame_div8 and ser_out are cleared to 0 and the counter returns to count zero; wide_mode and sel_a are changed only during reset.
- R10: Separate slip requests accumulate, one bit of boundary shift each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | 1 selects ser_a, 0 selects ser_b |
| ser_a | input | 1 | Serial input A |
| ser_b | input | 1 | Serial input B (loopback path) |
| wide_mode | input | 1 | 0: 4-clock word period, 1: 8-clock period for cascading |
| slip_req | input | 1 | Asynchronous boundary-slip request, hold at least two clocks |
| par_q | output | WORD_W | Parallel word, bit 0 = earliest bit |
| frame_div4 | output | 1 | Clock divided by 4 framing signal |
| frame_div8 | output | 1 | Clock divided by 8 framing signal |
| ser_out | output | 1 | Serial stream delayed by four clocks, for cascading |

## Verification
The assertions check on every cycle that par_q changes only where the framing signal of the active mode falls, that frame_div8 moves only with a falling frame_div4, that ser_out trails the selected input by four edges, and that each skipped count is a single cycle that follows a synchronized request and freezes the outputs. Only the bench scenarios can show that the loaded words hold the right bits in the right order. The same holds for the first word after reset in both modes, for a long request giving one slip and two requests giving two, and for the unselected input having no effect.

// File: rtl/sp_deser_pkg.sv
package sp_deser_pkg;
    typedef enum logic [1:0] {
        SLIP_IDLE    = 2'd0,
        SLIP_SWALLOW = 2'd1,
        SLIP_HELD    = 2'd2
    } slip_state_t;
endpackage

// File: rtl/sp_slip_sync.sv
module sp_slip_sync
    import sp_deser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic swallow
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   req_s;
    slip_state_t            state_q;
    slip_state_t            state_d;

    // metastability filter for the asynchronous request
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
        end
    end

    assign req_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLIP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLIP_IDLE:    state_d = req_s ? SLIP_SWALLOW : SLIP_IDLE;
            SLIP_SWALLOW: state_d = req_s ? SLIP_HELD : SLIP_IDLE;
            SLIP_HELD:    state_d = req_s ? SLIP_HELD : SLIP_IDLE;
            default:      state_d = SLIP_IDLE;
        endcase
    end

    // outputs: one swallowed count per request
    always_comb begin
        swallow = (state_q == SLIP_SWALLOW);
    end
endmodule

// File: rtl/sp_frame_div.sv
module sp_frame_div #(
    parameter int PHASE_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             wide,
    output logic [PHASE_W:0] cnt_q,
    output logic             load
);
    localparam logic [PHASE_W:0] STEP = 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!hold) begin
            cnt_q <= cnt_q + STEP;
        end
    end

    // terminal count of the active period, suppressed on a swallowed edge
    always_comb begin
        if (wide) begin
            load = !hold && (&cnt_q);
        end else begin
            load = !hold && (&cnt_q[PHASE_W-1:0]);
        end
    end
endmodule

// File: rtl/sp_shift_capture.sv
module sp_shift_capture #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              load,
    output logic [WORD_W-1:0] par_q,
    output logic              ser_out
);
    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] sr_d;

    // newest bit enters at the top, so the oldest ends up in bit 0
    assign sr_d = {din, sr_q[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            par_q <= '0;
        end else begin
            sr_q <= sr_d;
            if (load) begin
                par_q <= sr_d;
            end
        end
    end

    assign ser_out = sr_q[0];
endmodule

// File: rtl/sp_slip_deser.sv
module sp_slip_deser #(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a,
    input  logic              ser_a,
    input  logic              ser_b,
    input  logic              wide_mode,
    input  logic              slip_req,
    output logic [WORD_W-1:0] par_q,
    output logic              frame_div4,
    output logic              frame_div8,
    output logic              ser_out
);
    localparam int PHASE_W = $clog2(WORD_W);
    localparam int CNT_W   = PHASE_W + 1;

    logic             sin_w;
    logic             swallow_w;
    logic             load_w;
    logic [CNT_W-1:0] cnt_w;

    assign sin_w = sel_a ? ser_a : ser_b;

    sp_slip_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_slip (
        .clk      (clk),
        .rst      (rst),
        .req_async(slip_req),
        .swallow  (swallow_w)
    );

    sp_frame_div #(
        .PHASE_W(PHASE_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .hold (swallow_w),
        .wide (wide_mode),
        .cnt_q(cnt_w),
        .load (load_w)
    );

    sp_shift_capture #(
        .WORD_W(WORD_W)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .din    (sin_w),
        .load   (load_w),
        .par_q  (par_q),
        .ser_out(ser_out)
    );

    assign frame_div4 = cnt_w[PHASE_W-1];
    assign frame_div8 = cnt_w[PHASE_W];
endmodule

// File: rtl/sp_slip_deser_chk.sv
module sp_slip_deser_chk #(
    parameter int WORD_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_a,
    input logic              ser_a,
    input logic              ser_b,
    input logic              wide_mode,
    input logic              slip_req,
    input logic [WORD_W-1:0] par_q,
    input logic              frame_div4,
    input logic              frame_div8,
    input logic              ser_out,
    input logic              swallow
);
    logic       pick_w;
    logic [2:0] seen_q;

    assign pick_w = sel_a ? ser_a : ser_b;

    // edges since reset release, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (seen_q != 3'd7) begin
            seen_q <= seen_q + 3'd1;
        end
    end

    assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (par_q != $past(par_q)) |-> (wide_mode ? $fell(frame_div8) : $fell(frame_div4)));

    assert_div8_nest_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_div8) |-> $fell(frame_div4));

    assert_ser_delay_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_q >= 3'd4) |-> (ser_out == $past(pick_w, 4)));

    assert_single_swallow_R7: assert property (@(posedge clk) disable iff (rst)
        swallow |=> !swallow);

    assert_swallow_cause_R7: assert property (@(posedge clk) disable iff (rst)
        swallow |-> $past(slip_req, 3));

    assert_swallow_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        swallow |=> ($stable(frame_div4) && $stable(frame_div8) && $stable(par_q)));
endmodule

bind sp_slip_deser sp_slip_deser_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_a     (sel_a),
    .ser_a     (ser_a),
    .ser_b     (ser_b),
    .wide_mode (wide_mode),
    .slip_req  (slip_req),
    .par_q     (par_q),
    .frame_div4(frame_div4),
    .frame_div8(frame_div8),
    .ser_out   (ser_out),
    .swallow   (swallow_w)
);

// File: tb/sp_slip_deser_tb.sv
`timescale 1ns/1ps
module sp_slip_deser_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a = 1'b1;
    logic       ser_a = 1'b0;
    logic       ser_b = 1'b0;
    logic       wide_mode = 1'b0;
    logic       slip_req = 1'b0;
    logic [3:0] par_q;
    logic       frame_div4;
    logic       frame_div8;
    logic       ser_out;

    always #2 clk = ~clk;

    sp_slip_deser u_dut (
        .clk(clk), .rst(rst), .sel_a(sel_a), .ser_a(ser_a), .ser_b(ser_b),
        .wide_mode(wide_mode), .slip_req(slip_req), .par_q(par_q),
        .frame_div4(frame_div4), .frame_div8(frame_div8), .ser_out(ser_out)
    );

    typedef struct {
        logic [3:0] par;
        logic       fd4;
        logic       fd8;
        logic       so;
        logic       load;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         failures = 0;
    string      scen = "R9 start";
    logic [7:0] hist;
    logic [2:0] bcnt;
    int         edge_no;
    int         swallow_at;
    logic       prev_slip;
    logic [3:0] last_word;
    bit         done = 1'b0;

    task automatic check_val(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // driver: drives one bit for the next edge and pushes what that edge must produce
    task automatic tick(input logic b, input logic s);
        exp_t e;
        @(posedge clk);
        #1;
        rst = 1'b0;
        if (sel_a) begin ser_a = b; ser_b = ~b; end
        else       begin ser_b = b; ser_a = ~b; end
        slip_req = s;
        edge_no++;
        if (s && !prev_slip) swallow_at = edge_no + 3;
        prev_slip = s;
        hist = {hist[6:0], b};
        e.load = 1'b0;
        if (edge_no != swallow_at) begin
            bcnt = bcnt + 3'd1;
            if (wide_mode ? (bcnt == 3'd0) : (bcnt[1:0] == 2'd0)) begin
                e.load = 1'b1;
                last_word = {hist[0], hist[1], hist[2], hist[3]};
            end
        end
        e.par = last_word;
        e.fd4 = bcnt[1];
        e.fd8 = bcnt[2];
        e.so  = hist[3];
        sb_q.push_back(e);
    endtask

    task automatic run_bits(input logic [63:0] pat, input int n, input int slip_at, input int slip_len);
        for (int i = 0; i < n; i++) begin
            tick(pat[i], (i >= slip_at) && (i < slip_at + slip_len));
        end
    endtask

    // reset with new static settings; checks the cleared state (R9)
    task automatic do_reset(input logic wide, input logic sa);
        @(posedge clk);
        #1;
        rst = 1'b1;
        wide_mode = wide;
        sel_a = sa;
        slip_req = 1'b0;
        #2;
        hist = '0; bcnt = '0; edge_no = 0; swallow_at = -100;
        prev_slip = 1'b0; last_word = '0;
        sb_q.delete();
        repeat (2) @(posedge clk);
        #1;
        check_val("R9 reset par_q", 32'(par_q), 32'h0);
        check_val("R9 reset frames", 32'({frame_div8, frame_div4}), 32'h0);
        check_val("R9 reset ser_out", 32'(ser_out), 32'h0);
    endtask

    // monitor: one scoreboard item per edge taken out of reset
    always @(posedge clk) begin
        if (!rst) begin
            #2;
            if (sb_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL %s scoreboard actual=empty expected=item", scen);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check_val($sformatf("%s par_q %s", scen, e.load ? "load" : "hold"),
                          32'(par_q), 32'(e.par));
                check_val("R5 frames", 32'({frame_div8, frame_div4}), 32'({e.fd8, e.fd4}));
                check_val("R6 ser_out", 32'(ser_out), 32'(e.so));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0, 1'b1);
        scen = "R1/R3/R9 mode4 selA";
        run_bits(64'hA5C3_1E7F_0F96_D24B, 40, 1000, 0);

        do_reset(1'b0, 1'b0);
        scen = "R2 mode4 selB";
        run_bits(64'h3C5A_9E01_77F2_8B4D, 40, 1000, 0);

        do_reset(1'b1, 1'b1);
        scen = "R4/R9 mode8 selA";
        run_bits(64'h0123_4567_89AB_CDEF, 48, 1000, 0);

        do_reset(1'b1, 1'b0);
        scen = "R4/R2 mode8 selB";
        run_bits(64'hF0E1_D2C3_B4A5_9687, 48, 1000, 0);

        do_reset(1'b0, 1'b1);
        scen = "R7/R8 slip mode4";
        run_bits(64'h8421_1248_C639_5AA5, 40, 9, 3);

        do_reset(1'b0, 1'b1);
        scen = "R7 long slip";
        run_bits(64'h6D2B_93E4_17C8_A05F, 50, 10, 14);

        do_reset(1'b0, 1'b0);
        scen = "R10 two slips";
        run_bits(64'hB7E1_5163_2A4D_90C8, 24, 6, 3);
        run_bits(64'h1F2E_3D4C_5B6A_7988, 30, 5, 2);

        do_reset(1'b1, 1'b1);
        scen = "R8 slip mode8";
        run_bits(64'h9D3A_C571_E20B_6F48, 56, 13, 3);

        do_reset(1'b0, 1'b1);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule